// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block gathers single-cycle event pulses from the rest of a chip into a sticky status register. It raises one interrupt pin whenever a status bit that is set also has its enable bit set in a mask register. Software clears status bits by writing ones to them. Its handler can therefore write back the exact value it read and lose nothing that arrived in between. If a new event and a clearing write land on the same bit in the same clock, the event wins.

The pin has four signalling formats, chosen by two configuration bits. The level formats follow the masked condition directly, active low or active high. The pulse formats emit one fixed-width pulse, low-going or high-going, on each rising edge of the masked condition. The pulse width is a whole number of divided-clock periods, at least one. The divided clock is the system clock divided by a parameter. A small register port with a write strobe, an address and a combinational read path gives access to status, mask and configuration.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, status, mask and configuration read as zero, and the pin is high (level format, active low, no pending condition).
- R2: An event input bit that is 1 in a cycle sets the matching status bit at that clock edge. The bit stays set until it is cleared by software, and the new value is readable at address 0 in the following cycle.
- R3: A write to address 0 clears every status bit whose write-data bit is 1 and leaves every bit written with 0 unchanged. Writing 0xFFFFFF clears all bits, and writing back an earlier read value keeps events that arrived after that read.
- R4: If an event pulse and a clearing write hit the same status bit in the same clock, the bit ends up set.
- R5: Address 1 is the mask register, written and read whole. Address 2 is the configuration register: bit 0 selects pulse format (0 = level, 1 = pulse) and bit 1 selects the active level (0 = low, 1 = high). Configuration bits 23:2 read as zero.
- R6: The interrupt condition is the OR over all bits of (status AND mask). A set status bit whose mask bit is 0 has no effect on the pin.
- R7: In level format the pin equals the condition when bit 1 is 1 and its inverse when bit 1 is 0. It changes in the same cycle as the register update that changes the condition, and it returns to idle only when the contributing status bits are cleared or unmasked.
- R8: In pulse format, each rising edge of the condition makes the pin active for exactly DCLK_DIV*PULSE_DCLKS clock cycles, starting one cycle after the condition rises. At all other times the pin is at its idle level (the inverse of bit 1), including while the condition stays high.
- R9: A new rising edge of the condition during a pulse restarts the pulse count, so the pulse is extended.
- R10: Address 3 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 24 | Event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 status, 1 mask, 2 config, 3 reserved) |
| wdata | input | 24 | Register write data |
| rdata | output | 24 | Combinational read data for addr |
| irq_o | output | 1 | Interrupt pin |

## Verification
An event or write applied before a clock edge shows up in the registers and in read data right after that edge. A level-format pin follows in the same cycle. A pulse-format pin becomes active one edge later and stays active for the full pulse length. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares pin and read data on the next falling edge against a cycle model that applies the same latencies. Directed sequences also count the pin's active cycles to confirm the exact pulse width and the extension on retrigger.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS = 2'd0,
    ADR_MASK   = 2'd1,
    ADR_CFG    = 2'd2,
    ADR_RSVD   = 2'd3
  } reg_addr_e;

  // bit1 = active level high, bit0 = pulse format
  typedef struct packed {
    logic act_high;
    logic pulse;
  } out_cfg_t;

  function automatic int pulse_cycles(input int div, input int n_dclk);
    return div * n_dclk;
  endfunction

  function automatic logic pin_level(input logic active, input logic act_high);
    return act_high ? active : ~active;
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         pending_o
);
  logic [W-1:0] status_q, mask_q, clr_bits;

  assign clr_bits = clr_we ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_bits) | evt_i;
      if (mask_we) mask_q <= wdata_i;
    end
  end

  assign status_o  = status_q;
  assign mask_o    = mask_q;
  assign pending_o = |(status_q & mask_q);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (status_q == (($past(status_q) & ~$past(wdata_i)) | $past(evt_i))));
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (status_q == ($past(status_q) | $past(evt_i))));
  p_mask_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/evt_pulse_timer.sv
module evt_pulse_timer #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic rise_o,
  output logic busy_o
);
  localparam int CW = $clog2(LEN + 1);
  logic          cond_q;
  logic [CW-1:0] cnt_q;

  assign rise_o = cond_i & ~cond_q;
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cond_q <= cond_i;
      if (rise_o)       cnt_q <= CW'(LEN);
      else if (busy_o)  cnt_q <= cnt_q - 1'b1;
    end
  end

  p_pulse_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> (cnt_q == CW'(LEN)));
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_o && busy_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LEN));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int W           = 24,
  parameter int DCLK_DIV    = 4,
  parameter int PULSE_DCLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq_o
);
  localparam int PLEN = pulse_cycles(DCLK_DIV, PULSE_DCLKS);

  // named internal events
  logic         wr_status, wr_mask, wr_cfg;
  logic         pending, rise, busy, active;
  logic [W-1:0] status, mask;
  out_cfg_t     cfg_q;

  assign wr_status = wr_en && (addr == ADR_STATUS);
  assign wr_mask   = wr_en && (addr == ADR_MASK);
  assign wr_cfg    = wr_en && (addr == ADR_CFG);

  evt_status_bank #(.W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .clr_we(wr_status), .mask_we(wr_mask), .wdata_i(wdata),
    .status_o(status), .mask_o(mask), .pending_o(pending)
  );

  evt_pulse_timer #(.LEN(PLEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .cond_i(pending),
    .rise_o(rise), .busy_o(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= out_cfg_t'(wdata[1:0]);
  end

  always_comb begin
    case (reg_addr_e'(addr))
      ADR_STATUS: rdata = status;
      ADR_MASK:   rdata = mask;
      ADR_CFG:    rdata = {{(W-2){1'b0}}, cfg_q};
      default:    rdata = '0;
    endcase
  end

  assign active = cfg_q.pulse ? busy : pending;
  assign irq_o  = pin_level(active, cfg_q.act_high);

  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.pulse |-> (irq_o == (cfg_q.act_high ? |(status & mask) : ~|(status & mask))));
  p_pulse_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.pulse && !busy) |-> (irq_o == ~cfg_q.act_high));
  p_masked_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.pulse && ((status & mask) == '0)) |-> (irq_o == ~cfg_q.act_high));
  p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_RSVD) |-> (rdata == '0));
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q));
endmodule

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_evt_irq_ctrl;
  localparam int W = 24, DIV = 4, PD = 1;
  localparam int LEN = DIV * PD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] evt = '0, wdata = '0, rdata;
  logic wr_en = 1'b0, irq;
  logic [1:0] addr = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_irq_ctrl #(.W(W), .DCLK_DIV(DIV), .PULSE_DCLKS(PD)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq));

  // bench model
  logic [W-1:0] sm = '0, mm = '0;
  logic [1:0]   cm = '0;
  logic         pq = 1'b0;
  int           cn = 0;

  function automatic logic exp_pin();
    logic act;
    act = cm[0] ? (cn != 0) : (|(sm & mm));
    return cm[1] ? act : ~act;
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return sm;
      2'd1: return mm;
      2'd2: return {{(W-2){1'b0}}, cm};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [W-1:0] e, input logic w,
                            input logic [1:0] a, input logic [W-1:0] d);
    logic p;
    p = |(sm & mm);
    if (p && !pq) cn = LEN; else if (cn != 0) cn--;
    pq = p;
    sm = (sm & ~((w && a == 2'd0) ? d : '0)) | e;
    if (w && a == 2'd1) mm = d;
    if (w && a == 2'd2) cm = d[1:0];
  endtask

  // starts and ends at a falling edge
  task automatic step(input logic [W-1:0] e, input logic w,
                      input logic [1:0] a, input logic [W-1:0] d);
    evt = e; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    model_edge(e, w, a, d);
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    check(cm[0] ? "R8 pin" : "R7 pin", {23'd0, irq}, {23'd0, exp_pin()});
    case (a)
      2'd0: check("R2 status read", rdata, exp_rd(a));
      2'd3: check("R10 reserved read", rdata, exp_rd(a));
      default: check("R5 reg read", rdata, exp_rd(a));
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 2'd0, '0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int low;
    logic [W-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 pin idle high", {23'd0, irq}, 24'd1);
    for (int a = 0; a < 4; a++) begin
      addr = a[1:0]; #0.1;
      check("R1 reg zero", rdata, '0);
    end
    @(negedge clk);

    // R6: unmasked event has no effect
    step(24'h000010, 1'b0, 2'd0, '0);
    check("R6 unmasked pin idle", {23'd0, irq}, 24'd1);
    check("R2 event sets bit", rdata, 24'h000010);
    // R7 level active low once masked
    step('0, 1'b1, 2'd1, 24'h000010);
    check("R7 level active low", {23'd0, irq}, 24'd0);
    // R3 write-back keeps late events
    step('0, 1'b0, 2'd0, '0);
    snap = rdata;
    step(24'h000200, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd0, snap);
    check("R3 late event kept", rdata, 24'h000200);
    check("R7 cleared contributor releases pin", {23'd0, irq}, 24'd1);
    // R4 set wins
    step(24'h000001, 1'b1, 2'd0, 24'h000001);
    check("R4 set wins", rdata, 24'h000201);
    step('0, 1'b1, 2'd0, 24'hFFFFFF);
    check("R3 all ones clears", rdata, 24'h000000);
    // R5 cfg readback
    step('0, 1'b1, 2'd2, 24'hFFFFFF);
    check("R5 cfg upper zero", rdata, 24'h000003);
    // R10 reserved write ignored
    step('0, 1'b1, 2'd3, 24'h123456);
    step('0, 1'b0, 2'd2, '0);
    check("R10 cfg unchanged", rdata, 24'h000003);

    // R8 pulse width, low-going
    step('0, 1'b1, 2'd2, 24'h000001);
    step('0, 1'b1, 2'd1, 24'h000001);
    step(24'h000001, 1'b0, 2'd0, '0);
    check("R8 no pulse same cycle", {23'd0, irq}, 24'd1);
    low = 0;
    for (int i = 0; i < 10; i++) begin
      step('0, 1'b0, 2'd0, '0);
      if (!irq) low++;
    end
    check("R8 pulse width", low, LEN);
    check("R8 idle while condition high", {23'd0, irq}, 24'd1);
    // R9 retrigger extends
    step('0, 1'b1, 2'd0, 24'hFFFFFF);
    idle(6);
    step(24'h000001, 1'b0, 2'd0, '0);
    low = 0;
    step('0, 1'b1, 2'd0, 24'h000001); if (!irq) low++;
    step(24'h000001, 1'b0, 2'd0, '0); if (!irq) low++;
    for (int i = 0; i < 10; i++) begin
      step('0, 1'b0, 2'd0, '0);
      if (!irq) low++;
    end
    check("R9 retrigger extends pulse", low, LEN + 2);

    // random phase against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] e, d;
      logic w;
      logic [1:0] a;
      e = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom & 24'hFFFFFF) : '0;
      w = ($urandom % 3 == 0);
      a = 2'($urandom);
      d = 24'($urandom);
      if (a == 2'd2 && ($urandom % 4 != 0)) w = 1'b0;
      if (a == 2'd0 && ($urandom % 2 == 0)) d = sm;
      step(e, w, a, d);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule